// File: doc/BRIEF.md
# Two-Phase Polyphase Decimate-by-Two Fifth-Order Comb Stage

This block is one fifth-order nonrecursive comb-sum stage with impulse response 1, 5, 10, 10, 5, 1, built as a decimate-by-two polyphase filter. The rate is halved before any arithmetic takes place. Accepted input samples are steered in turn into one of two three-tap branches. Each branch therefore sees only half of the input rate. The even-indexed samples (index 0, 2, 4, ... counted from reset) feed the "late" branch, with taps 5, 10, 1. The odd-indexed samples feed the "early" branch, with taps 1, 10, 5. When an odd-indexed sample arrives, the two branch results are added, and that sum is the decimated output.

Each branch is written in transposed form, so every adder performs at most one addition per branch sample. No multiplier is used anywhere. Each branch builds its input times five once, as a shift by two plus the input, and then reuses that value: times ten is the same value shifted left by one. The output is 5 bits wider than the input, which covers the DC gain of 32.

A two-state phase machine follows which branch the next accepted sample goes to. Its states are `PH_EVEN` (the next sample goes to the late branch) and `PH_ODD` (the next sample goes to the early branch). There are two transitions:

- `T_EVEN_TAKEN`: `PH_EVEN` to `PH_ODD`, when a sample is accepted in `PH_EVEN`.
- `T_ODD_TAKEN`: `PH_ODD` to `PH_EVEN`, when a sample is accepted in `PH_ODD`.

The machine stays in its state on every cycle where `in_valid` is low.

Top module: `cic5_poly_dec2`

## Requirements
- R1: After reset, `out_valid` is 0, the phase machine is in `PH_EVEN`, and all branch storage is zero. The first output after reset is therefore computed as if every earlier input were zero.
- R2: For every second accepted input (the odd-indexed one, counting from 0 after reset), `out_valid` is high for exactly one cycle, on the clock cycle after that input is accepted. No other cycle has `out_valid` high, so two output pulses are never adjacent.
- R3: A cycle with `in_valid` low has no effect: the phase, the branch storage and the held partial sum all keep their values. Idle gaps of any length inside the input stream leave the output values unchanged.
- R4: Every output equals sample 2m+1 of the full six-tap filter 1,5,10,10,5,1 applied to the accepted input sequence, with inputs before reset taken as zero. The result is bit-exact for any signed inputs.
- R5: Even-indexed samples feed the branch with taps 5,10,1. Odd-indexed samples feed the branch with taps 1,10,5. A unit impulse at index 0 gives the outputs 5, 10, 1. A unit impulse at index 1 gives the outputs 1, 10, 5.
- R6: `out_data` is IN_W+5 bits wide, signed two's complement. A constant input c settles to exactly 32*c. This includes the most negative and most positive input codes, with no wrap-around.
- R7: Asserting reset in the middle of a stream discards any half-finished pair. The index count restarts at 0 (even) for the first sample accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_data carries a sample to accept this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | High for one cycle when out_data holds a new decimated sample |
| out_data | output | IN_W+5 | Signed decimated output sample |

## Verification
The bench builds the block with IN_W = 8, so the output is 13 bits wide. With this width, uniformly random samples regularly reach the extreme codes -128 and +127. The constant-input runs therefore drive the exact full-scale corners, -4096 and +4064, where any missing bit of growth would show up as a wrap. The small width also keeps the reference sums easy to compute in full while still covering every bit of the shift-and-add products.

// File: rtl/cic5_pkg.sv
package cic5_pkg;

    // Phase of the polyphase commutator: which branch takes the next sample
    typedef enum logic [0:0] {
        PH_EVEN = 1'b0,   // next accepted sample has an even index (late branch)
        PH_ODD  = 1'b1    // next accepted sample has an odd index (early branch)
    } phase_e;

    // Bit growth of a fifth-order stage: log2(32)
    localparam int GROWTH = 5;

endpackage

// File: rtl/cic5_times5.sv
module cic5_times5 #(
    parameter int IN_W  = 16,
    parameter int OUT_W = IN_W + cic5_pkg::GROWTH
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] x1,
    output logic signed [OUT_W-1:0] x5,
    output logic signed [OUT_W-1:0] x10
);

    localparam int EXT_W = OUT_W - IN_W;

    // One shared 5x product; 10x reuses it with a single shift
    always_comb begin
        x1  = {{EXT_W{x[IN_W-1]}}, x};
        x5  = (x1 <<< 2) + x1;
        x10 = x5 <<< 1;
    end

endmodule

// File: rtl/cic5_branch.sv
module cic5_branch #(
    parameter int IN_W   = 16,
    parameter int OUT_W  = IN_W + cic5_pkg::GROWTH,
    parameter bit MIRROR = 1'b0   // 0: taps 1,10,5   1: taps 5,10,1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y
);

    logic signed [OUT_W-1:0] p1, p5, p10;
    logic signed [OUT_W-1:0] c0, c1, c2;
    logic signed [OUT_W-1:0] s1, s2;

    cic5_times5 #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scale (
        .x   (x),
        .x1  (p1),
        .x5  (p5),
        .x10 (p10)
    );

    // Tap order picked by parameter; the 10 tap sits in the middle either way
    generate
        if (MIRROR) begin : g_late
            assign c0 = p5;
            assign c1 = p10;
            assign c2 = p1;
        end else begin : g_early
            assign c0 = p1;
            assign c1 = p10;
            assign c2 = p5;
        end
    endgenerate

    // Transposed form: one adder per register, one add per branch sample
    assign y = c0 + s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else if (en) begin
            s1 <= c1 + s2;
            s2 <= c2;
        end
    end

    // R3: storage is untouched on cycles without a sample for this branch
    assert_branch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(s1) && $stable(s2)));

endmodule

// File: rtl/cic5_phase_fsm.sv
module cic5_phase_fsm
    import cic5_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output phase_e phase,
    output logic   take_even,
    output logic   take_odd
);

    phase_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_EVEN;
        else        state_q <= state_d;
    end

    // Next state: T_EVEN_TAKEN and T_ODD_TAKEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EVEN: if (in_valid) state_d = PH_ODD;
            PH_ODD:  if (in_valid) state_d = PH_EVEN;
            default: state_d = PH_EVEN;
        endcase
    end

    // Outputs: steer the accepted sample into one branch
    always_comb begin
        take_even = 1'b0;
        take_odd  = 1'b0;
        unique case (state_q)
            PH_EVEN: take_even = in_valid;
            PH_ODD:  take_odd  = in_valid;
            default: ;
        endcase
    end

    assign phase = state_q;

    // R3: the commutator only moves on an accepted sample
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state_q));

    // R2: every accepted sample flips the phase
    assert_phase_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (state_q != $past(state_q)));

endmodule

// File: rtl/cic5_poly_dec2.sv
module cic5_poly_dec2 #(
    parameter int IN_W = 16,
    localparam int OUT_W = IN_W + cic5_pkg::GROWTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);

    import cic5_pkg::*;

    phase_e                  phase;
    logic                    take_even, take_odd;
    logic signed [OUT_W-1:0] late_y, early_y;
    logic signed [OUT_W-1:0] late_hold;

    cic5_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .phase     (phase),
        .take_even (take_even),
        .take_odd  (take_odd)
    );

    // Even-indexed samples: taps 5,10,1
    cic5_branch #(.IN_W(IN_W), .OUT_W(OUT_W), .MIRROR(1'b1)) u_late (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (take_even),
        .x     (in_data),
        .y     (late_y)
    );

    // Odd-indexed samples: taps 1,10,5
    cic5_branch #(.IN_W(IN_W), .OUT_W(OUT_W), .MIRROR(1'b0)) u_early (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (take_odd),
        .x     (in_data),
        .y     (early_y)
    );

    // Hold the late-branch result until its odd partner arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         late_hold <= '0;
        else if (take_even) late_hold <= late_y;
    end

    // Combine the two branches once per pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take_odd;
            if (take_odd) out_data <= early_y + late_hold;
        end
    end

    // R2: an odd sample always yields an output the next cycle
    assert_pair_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == PH_ODD) |=> out_valid);

    // R2: an output only follows an accepted odd sample
    assert_output_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) && $past(phase) == PH_ODD));

    // R2: output pulses are never back to back
    assert_no_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: held partial sum is kept while no even sample arrives
    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(late_hold));

endmodule

// File: tb/cic5_poly_dec2_tb.sv
module cic5_poly_dec2_tb;

    localparam int IN_W  = 8;
    localparam int OUT_W = IN_W + 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint hist[$];
    longint exp_q[$];
    string  tag_q[$];
    string  cur_tag = "R4";
    longint got_log[$];

    always #2.5 clk = ~clk;

    cic5_poly_dec2 #(.IN_W(IN_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint ref_out(input int n);
        longint h[6] = '{1, 5, 10, 10, 5, 1};
        longint acc = 0;
        for (int k = 0; k < 6; k++)
            if (n - k >= 0) acc += h[k] * hist[n-k];
        return acc;
    endfunction

    // Driver: push one sample, optionally after idle cycles
    task automatic send(input int v, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v[IN_W-1:0];
        hist.push_back(longint'(v));
        if (hist.size() % 2 == 0) begin
            exp_q.push_back(ref_out(hist.size() - 1));
            tag_q.push_back(cur_tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        hist.delete();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare on every output pulse
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_log.push_back(longint'(out_data));
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", longint'(out_data), 0);
            end else begin
                longint e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(longint'(out_data) == e, t, longint'(out_data), e);
            end
        end
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        check($bits(out_data) == IN_W + 5, "R6 output width", $bits(out_data), IN_W + 5);

        // R5: impulse at even index 0 -> 5,10,1
        cur_tag = "R5";
        got_log.delete();
        send(1, 0);
        for (int i = 0; i < 7; i++) send(0, 0);
        idle(3);
        check(got_log.size() == 4, "R2 pulses per pair", got_log.size(), 4);
        if (got_log.size() >= 3) begin
            check(got_log[0] == 5,  "R5 even impulse tap0", got_log[0], 5);
            check(got_log[1] == 10, "R5 even impulse tap1", got_log[1], 10);
            check(got_log[2] == 1,  "R5 even impulse tap2", got_log[2], 1);
        end

        // R5: impulse at odd index -> 1,10,5
        got_log.delete();
        send(0, 0);
        send(1, 0);
        for (int i = 0; i < 6; i++) send(0, 0);
        idle(3);
        if (got_log.size() >= 3) begin
            check(got_log[0] == 1,  "R5 odd impulse tap0", got_log[0], 1);
            check(got_log[1] == 10, "R5 odd impulse tap1", got_log[1], 10);
            check(got_log[2] == 5,  "R5 odd impulse tap2", got_log[2], 5);
        end else begin
            check(1'b0, "R5 odd impulse count", got_log.size(), 4);
        end

        // R7: reset with a half pair pending; the phase restarts at even
        cur_tag = "R7";
        send(40, 0);
        send(-17, 0);
        send(99, 0);
        do_reset();
        check(out_valid == 1'b0, "R1 out_valid after mid reset", longint'(out_valid), 0);
        got_log.delete();
        send(1, 0);
        send(0, 0);
        idle(3);
        check(got_log.size() == 1 && got_log[0] == 5, "R7 restart phase even",
              got_log.size() > 0 ? got_log[0] : -1, 5);
        for (int i = 0; i < 6; i++) send(0, 0);
        idle(3);

        // R4: continuous random stream
        cur_tag = "R4";
        for (int i = 0; i < 400; i++) send(int'($urandom_range(0, 255)) - 128, 0);

        // R3: random stream with idle gaps
        cur_tag = "R3";
        for (int i = 0; i < 300; i++)
            send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 3)));
        idle(3);
        // R3: long idle, no output
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R3 no output while idle", longint'(out_valid), 0);
        end

        // R6: constant full-scale inputs settle to 32*c
        cur_tag = "R6";
        for (int i = 0; i < 12; i++) send(-128, 0);
        idle(3);
        check(got_log[got_log.size()-1] == -4096, "R6 negative full scale",
              got_log[got_log.size()-1], -4096);
        for (int i = 0; i < 12; i++) send(127, 0);
        idle(3);
        check(got_log[got_log.size()-1] == 4064, "R6 positive full scale",
              got_log[got_log.size()-1], 4064);

        // R2: all expected outputs consumed
        idle(4);
        check(exp_q.size() == 0, "R2 pending outputs", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule